// File: doc/BRIEF.md
# Multi-Master Doorbell Unit

This block is a single doorbell that several bus masters ring to tell one receiver that something happened, with no payload. Every bus write carries a 5-bit side-band tag naming the master that issued it. A write of one to the ring register marks that master's bit in a seen word unconditionally. It also marks the bit in a pending word, but only when the receiver has allowed that master in its allow mask.

The receiver learns of work through a level interrupt that stays high while any pending bit is set. It reads the pending word, services the masters it finds there, and writes the same value back to clear exactly those bits. The seen word is cleared the same way and serves as a diagnostic record of every ring, filtered or not.

The interrupt comes from a two-state machine. In state IRQ_QUIET the output is low; the transition raise moves it to IRQ_RAISED when the pending word is non-zero. In IRQ_RAISED the output is high; the transition drop returns it to IRQ_QUIET when the pending word is all zero. Register reads are captured into a read-data register one cycle after the read strobe.

Top module: `db_doorbell_unit`

## Requirements
- R1: After reset the allow mask, seen word and pending word are all zero, irq is low and rdata is zero.
- R2: A write to word 0 (ring) with wdata bit 0 set sets bit m of the seen word, where m is wr_master, whatever the allow mask holds. A ring write with bit 0 clear changes nothing.
- R3: A ring from master m sets pending bit m only if allow bit m is set when the ring write arrives. A ring from a master that is not allowed leaves the pending word unchanged.
- R4: A write to word 1 loads the whole allow mask (bit m for master m). Reading word 1 returns the mask.
- R5: A write to word 3 clears each pending bit whose wdata bit is one and keeps each bit whose wdata bit is zero. Reading word 3 returns the pending word.
- R6: A write to word 2 clears each seen bit whose wdata bit is one and keeps the others. Reading word 2 returns the seen word.
- R7: irq rises on the clock edge after the edge that first sets a pending bit, and falls on the clock edge after the edge that clears the last pending bit.
- R8: rdata takes the selected word on the clock edge that samples rd_en and holds its value in every cycle without a read. Reading word 0 returns zero.
- R9: Pending follows arrival-time gating. Setting an allow bit later does not turn an earlier filtered ring into a pending bit, and clearing an allow bit does not remove a pending bit already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| reg_sel | input | 2 | Word select: 0 ring, 1 allow, 2 seen, 3 pending |
| wdata | input | 32 | Write data |
| wr_master | input | 5 | Tag of the master issuing the write |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while work is pending |

## Verification
A write changes the allow, seen and pending words on the clock edge that samples it, so the bench reads them back with a read issued after that edge. The read data is due on the edge that samples rd_en, and the bench samples it on the following falling edge. irq lags the pending word by exactly one more edge. The bench checks it low at the falling edge just after the setting write and high one cycle later, and it checks the fall the same way after the clearing write. Every sample is taken on a falling edge, half a period away from the edge that updates the value.

// File: rtl/db_pkg.sv
package db_pkg;
    localparam int REG_W = 32;
    localparam int MID_W = 5;

    // word index of each register; the index itself is the bus decode
    typedef enum logic [1:0] {
        SEL_RING    = 2'd0,
        SEL_ALLOW   = 2'd1,
        SEL_SEEN    = 2'd2,
        SEL_PENDING = 2'd3
    } db_sel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } db_irq_e;

    typedef struct packed {
        logic ring;
        logic allow;
        logic seen;
        logic pending;
    } db_wstb_t;
endpackage

// File: rtl/db_regdec.sv
module db_regdec
    import db_pkg::*;
(
    input  logic       wr_en,
    input  logic [1:0] reg_sel,
    output db_wstb_t   wstb,
    output db_sel_e    rsel
);
    db_sel_e sel;
    assign sel  = db_sel_e'(reg_sel);
    assign rsel = sel;

    always_comb begin
        wstb = '0;
        if (wr_en) begin
            unique case (sel)
                SEL_RING:    wstb.ring    = 1'b1;
                SEL_ALLOW:   wstb.allow   = 1'b1;
                SEL_SEEN:    wstb.seen    = 1'b1;
                SEL_PENDING: wstb.pending = 1'b1;
                default:     wstb         = '0;
            endcase
        end
    end
endmodule

// File: rtl/db_bit_bank.sv
module db_bit_bank
    import db_pkg::*;
#(
    parameter int NUM_MASTERS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ring_we,
    input  logic [MID_W-1:0]       ring_id,
    input  logic                   seen_clr_we,
    input  logic                   pend_clr_we,
    input  logic [NUM_MASTERS-1:0] clr_bits,
    input  logic [NUM_MASTERS-1:0] allow,
    output logic [NUM_MASTERS-1:0] seen,
    output logic [NUM_MASTERS-1:0] pend
);
    // one cell per master; a ring outranks a clear of the same bit
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_cell
        logic hit;
        logic seen_keep;
        logic pend_keep;

        assign hit       = ring_we && (ring_id == MID_W'(m));
        assign seen_keep = seen[m] && !(seen_clr_we && clr_bits[m]);
        assign pend_keep = pend[m] && !(pend_clr_we && clr_bits[m]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seen[m] <= 1'b0;
                pend[m] <= 1'b0;
            end else begin
                seen[m] <= hit || seen_keep;
                pend[m] <= (hit && allow[m]) || pend_keep;
            end
        end
    end
endmodule

// File: rtl/db_irq_fsm.sv
module db_irq_fsm
    import db_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_any,
    output logic irq
);
    db_irq_e state_q;
    db_irq_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pend_any)  state_d = IRQ_RAISED; // raise
            IRQ_RAISED: if (!pend_any) state_d = IRQ_QUIET;  // drop
            default:                   state_d = IRQ_QUIET;
        endcase
    end

    assign irq = (state_q == IRQ_RAISED);
endmodule

// File: rtl/db_doorbell_unit.sv
module db_doorbell_unit
    import db_pkg::*;
#(
    parameter int NUM_MASTERS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] wdata,
    input  logic [MID_W-1:0] wr_master,
    output logic [REG_W-1:0] rdata,
    output logic             irq
);
    db_wstb_t               wstb;
    db_sel_e                rsel;
    logic [NUM_MASTERS-1:0] allow_q;
    logic [NUM_MASTERS-1:0] seen_q;
    logic [NUM_MASTERS-1:0] pend_q;
    logic [REG_W-1:0]       rd_word;

    db_regdec u_dec (
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wstb    (wstb),
        .rsel    (rsel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          allow_q <= '0;
        else if (wstb.allow) allow_q <= wdata[NUM_MASTERS-1:0];
    end

    db_bit_bank #(.NUM_MASTERS(NUM_MASTERS)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .ring_we     (wstb.ring && wdata[0]),
        .ring_id     (wr_master),
        .seen_clr_we (wstb.seen),
        .pend_clr_we (wstb.pending),
        .clr_bits    (wdata[NUM_MASTERS-1:0]),
        .allow       (allow_q),
        .seen        (seen_q),
        .pend        (pend_q)
    );

    db_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_any (|pend_q),
        .irq      (irq)
    );

    always_comb begin
        unique case (rsel)
            SEL_RING:    rd_word = '0;
            SEL_ALLOW:   rd_word = REG_W'(allow_q);
            SEL_SEEN:    rd_word = REG_W'(seen_q);
            SEL_PENDING: rd_word = REG_W'(pend_q);
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end
endmodule

// File: rtl/db_doorbell_sva.sv
module db_doorbell_sva
    import db_pkg::*;
#(
    parameter int NUM_MASTERS = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [1:0]             reg_sel,
    input logic [REG_W-1:0]       wdata,
    input logic [MID_W-1:0]       wr_master,
    input logic                   irq,
    input logic [NUM_MASTERS-1:0] allow_q,
    input logic [NUM_MASTERS-1:0] seen_q,
    input logic [NUM_MASTERS-1:0] pend_q
);
    logic ring_wr;
    assign ring_wr = wr_en && (reg_sel == 2'd0) && wdata[0];

    AST_RING_MARKS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_wr && (int'(wr_master) < NUM_MASTERS)) |=> seen_q[$past(wr_master)]); // R2

    AST_NEW_PEND_WAS_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(allow_q)) == '0); // R3

    AST_NEW_PEND_NEEDS_RING: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q)) != '0) |-> $past(ring_wr)); // R3

    AST_ALLOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_sel == 2'd1) |=> $stable(allow_q)); // R4

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd3) |=> ((pend_q & $past(wdata[NUM_MASTERS-1:0])) == '0)); // R5

    AST_IRQ_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|pend_q))); // R7
endmodule

bind db_doorbell_unit db_doorbell_sva #(.NUM_MASTERS(NUM_MASTERS)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .reg_sel   (reg_sel),
    .wdata     (wdata),
    .wr_master (wr_master),
    .irq       (irq),
    .allow_q   (allow_q),
    .seen_q    (seen_q),
    .pend_q    (pend_q)
);

// File: tb/tb_db_doorbell_unit.sv
module tb_db_doorbell_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] wdata = '0;
    logic [4:0]  wr_master = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [1:0] W_RING = 2'd0, W_ALLOW = 2'd1, W_SEEN = 2'd2, W_PEND = 2'd3;

    always #10 clk = ~clk; // 50 MHz

    db_doorbell_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wdata(wdata), .wr_master(wr_master),
        .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] sel, input logic [31:0] d, input logic [4:0] mid);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wdata = d; wr_master = mid;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic expect_word(input string req, input logic [1:0] sel, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(sel, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        check("R1 rdata", rdata, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        expect_word("R1 allow", W_ALLOW, 32'h0);
        expect_word("R1 seen", W_SEEN, 32'h0);
        expect_word("R1 pending", W_PEND, 32'h0);
    endtask

    task automatic t_ring_filtered;
        bus_wr(W_RING, 32'h1, 5'd5);
        expect_word("R2 seen after filtered ring", W_SEEN, 32'h0000_0020);
        expect_word("R3 pending after filtered ring", W_PEND, 32'h0);
        check("R3 irq after filtered ring", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_ring_bit0_clear;
        bus_wr(W_RING, 32'hFFFF_FFFE, 5'd6);
        expect_word("R2 ring with bit0 low", W_SEEN, 32'h0000_0020);
    endtask

    task automatic t_allow_rw;
        bus_wr(W_ALLOW, 32'h8000_0021, 5'd0);
        expect_word("R4 allow readback", W_ALLOW, 32'h8000_0021);
        expect_word("R9 late allow keeps old ring filtered", W_PEND, 32'h0);
    endtask

    task automatic t_ring_allowed;
        bus_wr(W_RING, 32'h1, 5'd0);
        check("R7 irq one edge after set", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R7 irq raised", {31'h0, irq}, 32'h1);
        expect_word("R3 pending allowed ring", W_PEND, 32'h0000_0001);
        bus_wr(W_RING, 32'h1, 5'd3);
        expect_word("R3 pending, master 3 not allowed", W_PEND, 32'h0000_0001);
        expect_word("R2 seen, master 3", W_SEEN, 32'h0000_0029);
    endtask

    task automatic t_clear;
        bus_wr(W_PEND, 32'h0000_0002, 5'd0);
        expect_word("R5 zero bits keep pending", W_PEND, 32'h0000_0001);
        check("R7 irq stays high", {31'h0, irq}, 32'h1);
        bus_wr(W_PEND, 32'h0000_0001, 5'd0);
        check("R7 irq one edge after clear", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R7 irq dropped", {31'h0, irq}, 32'h0);
        expect_word("R5 pending cleared", W_PEND, 32'h0);
        bus_wr(W_SEEN, 32'h0000_0008, 5'd0);
        expect_word("R6 seen partial clear", W_SEEN, 32'h0000_0021);
    endtask

    task automatic t_disable_keeps;
        bus_wr(W_RING, 32'h1, 5'd31);
        bus_wr(W_ALLOW, 32'h0, 5'd0);
        expect_word("R9 disable keeps pending", W_PEND, 32'h8000_0000);
        check("R9 irq still high", {31'h0, irq}, 32'h1);
        bus_wr(W_PEND, 32'hFFFF_FFFF, 5'd0);
        @(negedge clk);
        check("R5 full clear drops irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_read_path;
        logic [31:0] v;
        expect_word("R8 ring word reads zero", W_RING, 32'h0);
        bus_rd(W_SEEN, v);
        check("R6 seen before hold", v, 32'h8000_0021);
        repeat (2) @(negedge clk);
        check("R8 rdata holds idle", rdata, 32'h8000_0021);
        bus_wr(W_SEEN, 32'hFFFF_FFFF, 5'd0);
        check("R8 rdata holds over write", rdata, 32'h8000_0021);
        expect_word("R6 seen fully cleared", W_SEEN, 32'h0);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ring_filtered();
        t_ring_bit0_clear();
        t_allow_rw();
        t_ring_allowed();
        t_clear();
        t_disable_keeps();
        t_read_path();
        finish_run();
    end
endmodule